// File: doc/BRIEF.md
# Boot Table Section Loader

This block takes a table of code and data sections, delivered as a stream of 32-bit words with a valid/ready handshake, and writes each section into memory through a simple write port. Every section begins with a header of two words: a byte count, then the destination byte address. The data words of the section follow the header. A header whose byte count is zero closes the table. At that point the block pulses `done` and presents the address where execution should begin.

Two table formats are supported, and the `fmt_i` input picks one per table. In the standard format the first word of the table is an entry address, and that address becomes the jump target. In the header-only format there is no leading word, and the jump target is the base address of the last section that was loaded. Section bytes are packed big-endian in each word. The final word of a section that does not fill four bytes carries byte enables only for the bytes that belong to it.

`in_last` marks the final word of the stream. If the stream ends anywhere other than on the terminating zero count, the block flags an error. After a `done` or an error, the block is ready for the next table.

Top module: `bt_loader`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `done`, `err` and `mem_we` are 0 (given `in_valid` low) and `jump_addr` is 0.
- R2: With `fmt_i` = 0 (standard format), the first word of a table is taken as the entry address, and on termination `jump_addr` equals that word.
- R3: With `fmt_i` = 1 (header-only format), no leading word is consumed. On termination `jump_addr` equals the destination address of the last section loaded in that table, or 0 if the table held no section.
- R4: A section header is a byte-count word followed by a destination-address word. Data word k of the section (k counted from 0) is written with `mem_data` equal to the input word, at `mem_addr` = destination + 4·k, and each input data word produces exactly one write.
- R5: Each write of a section has `mem_be` = 4'b1111 while 4 or more bytes remain. For the last word, the remaining byte count gives the byte enables: 1 byte gives 4'b1000, 2 bytes give 4'b1100, 3 bytes give 4'b1110 (bit 3 enables `mem_data[31:24]`, the first byte in the stream).
- R6: A byte-count word of zero ends the table and gives a one-cycle `done` pulse. `jump_addr` changes only with `done` and then holds. `fmt_i` is sampled in the cycle in which the first word of a table is presented, so tables of either format can follow one another directly.
- R7: While a write is presented and `mem_ready` is low, `in_ready` is low, and `mem_we`, `mem_addr`, `mem_be` and `mem_data` hold unchanged until the write is taken.
- R8: If a word accepted with `in_last` high is anything other than a zero byte-count word, `err` pulses for one cycle and no `done` follows. A data word carrying `in_last` is still written. The block then waits for a new table.
- R9: `done` and `err` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_i | input | 1 | Table format: 0 standard (leading entry word), 1 header-only |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Marks the final word of the stream |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 32 | Write data, first byte in bits 31:24 |
| mem_be | output | 4 | Byte enables, bit 3 for bits 31:24 |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | One-cycle pulse at table end |
| err | output | 1 | One-cycle pulse when the stream ends early |
| jump_addr | output | ADDR_W | Execution start address, valid from `done` |

## Verification
The bench builds the loader with the default ADDR_W and CNT_W of 32. The full destination and entry words therefore reach the address port and the jump target unchanged, and the reference model can compare them bit for bit. Section lengths of 1, 2, 3, 5, 6, 7 and 8 bytes cover every tail enable pattern as well as the exact-multiple case. A pseudo-random `mem_ready` pattern, together with gaps in `in_valid`, puts stalls on first, middle and last words. Both formats run back to back, and the sequence includes an empty header-only table and two truncated streams, one cut inside a header and one cut inside data.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_BEGIN,
        ST_COUNT,
        ST_BASE,
        ST_DATA
    } bt_state_e;

    typedef enum logic {
        FMT_STD = 1'b0,
        FMT_GPH = 1'b1
    } bt_fmt_e;

    typedef struct packed {
        logic done;
        logic err;
    } bt_evt_t;

    // Byte enables for a trailing word holding 1..3 bytes, big-endian lanes.
    function automatic logic [WORD_BYTES-1:0] bt_tail_mask(input logic [1:0] tail);
        logic [WORD_BYTES-1:0] m;
        case (tail)
            2'd1:    m = 4'b1000;
            2'd2:    m = 4'b1100;
            2'd3:    m = 4'b1110;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bt_remain.sv
module bt_remain
    import bt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [CNT_W-1:0]      load_val,
    input  logic                  step,
    output logic [WORD_BYTES-1:0] be,
    output logic                  last_word
);
    localparam logic [CNT_W-1:0] STEP_BYTES = CNT_W'(WORD_BYTES);

    logic [CNT_W-1:0] rem_q;

    assign last_word = (rem_q <= STEP_BYTES);
    assign be        = (rem_q >= STEP_BYTES) ? '1 : bt_tail_mask(rem_q[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (step) begin
            rem_q <= last_word ? '0 : rem_q - STEP_BYTES;
        end
    end
endmodule

// File: rtl/bt_addr.sv
module bt_addr
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + INC;
        end
    end
endmodule

// File: rtl/bt_seq.sv
module bt_seq
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fmt_i,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic              mem_ready,
    input  logic              last_word,
    output logic              in_ready,
    output logic              mem_we,
    output logic              rem_load,
    output logic              addr_load,
    output logic              step,
    output bt_evt_t           evt,
    output logic [ADDR_W-1:0] jump_addr
);
    bt_state_e         st_q;
    bt_fmt_e           fmt_q;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] base_q;
    logic              accept;
    logic              is_term;

    always_comb begin
        case (st_q)
            ST_BEGIN: in_ready = (fmt_i == FMT_STD);
            ST_DATA:  in_ready = mem_ready;
            default:  in_ready = 1'b1;
        endcase
    end

    assign accept    = in_valid && in_ready;
    assign is_term   = (in_data == '0);
    assign mem_we    = (st_q == ST_DATA) && in_valid;
    assign rem_load  = (st_q == ST_COUNT) && accept && !is_term;
    assign addr_load = (st_q == ST_BASE) && accept;
    assign step      = (st_q == ST_DATA) && accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_BEGIN;
            fmt_q     <= FMT_STD;
            start_q   <= '0;
            base_q    <= '0;
            jump_addr <= '0;
            evt       <= '0;
        end else begin
            evt <= '0;
            case (st_q)
                ST_BEGIN: begin
                    base_q <= '0;
                    if (in_valid) begin
                        fmt_q <= bt_fmt_e'(fmt_i);
                        if (fmt_i == FMT_STD) begin
                            start_q <= in_data[ADDR_W-1:0];
                            if (in_last) evt.err <= 1'b1;
                            else         st_q    <= ST_COUNT;
                        end else begin
                            st_q <= ST_COUNT;
                        end
                    end
                end
                ST_COUNT: begin
                    if (accept) begin
                        if (is_term) begin
                            evt.done  <= 1'b1;
                            jump_addr <= (fmt_q == FMT_STD) ? start_q : base_q;
                            st_q      <= ST_BEGIN;
                        end else if (in_last) begin
                            evt.err <= 1'b1;
                            st_q    <= ST_BEGIN;
                        end else begin
                            st_q <= ST_BASE;
                        end
                    end
                end
                ST_BASE: begin
                    if (accept) begin
                        base_q <= in_data[ADDR_W-1:0];
                        if (in_last) begin
                            evt.err <= 1'b1;
                            st_q    <= ST_BEGIN;
                        end else begin
                            st_q <= ST_DATA;
                        end
                    end
                end
                default: begin
                    if (accept) begin
                        if (in_last) begin
                            evt.err <= 1'b1;
                            st_q    <= ST_BEGIN;
                        end else if (last_word) begin
                            st_q <= ST_COUNT;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bt_loader.sv
module bt_loader
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fmt_i,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     in_data,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_data,
    output logic [WORD_BYTES-1:0] mem_be,
    input  logic                  mem_ready,
    output logic                  done,
    output logic                  err,
    output logic [ADDR_W-1:0]     jump_addr
);
    logic    rem_load;
    logic    addr_load;
    logic    step;
    logic    last_word;
    bt_evt_t evt;

    bt_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fmt_i     (fmt_i),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .mem_ready (mem_ready),
        .last_word (last_word),
        .in_ready  (in_ready),
        .mem_we    (mem_we),
        .rem_load  (rem_load),
        .addr_load (addr_load),
        .step      (step),
        .evt       (evt),
        .jump_addr (jump_addr)
    );

    bt_remain #(.CNT_W(CNT_W)) u_remain (
        .clk       (clk),
        .rst       (rst),
        .load      (rem_load),
        .load_val  (in_data[CNT_W-1:0]),
        .step      (step),
        .be        (mem_be),
        .last_word (last_word)
    );

    bt_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load),
        .load_val (in_data[ADDR_W-1:0]),
        .step     (step),
        .addr     (mem_addr)
    );

    assign mem_data = in_data;
    assign done     = evt.done;
    assign err      = evt.err;
endmodule

// File: rtl/bt_loader_chk.sv
module bt_loader_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              mem_ready,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] jump_addr
);
    // R5: only contiguous leading-byte patterns appear on a write
    a_r5_lane_shape: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_be == 4'b1111 || mem_be == 4'b1110 ||
                    mem_be == 4'b1100 || mem_be == 4'b1000));

    // R4: back-to-back writes within a section advance by one word
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_ready) |=> (!mem_we || mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R7: a stalled write keeps its address and lanes
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_be)));

    // R7: no input word taken while the memory stalls a write
    a_r7_no_accept: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ready) |-> !in_ready);

    // R9: pulses are single-cycle and exclusive
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R6: the jump target moves only together with done
    a_r6_jump_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(jump_addr));
endmodule

bind bt_loader bt_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_ready (mem_ready),
    .done      (done),
    .err       (err),
    .jump_addr (jump_addr)
);

// File: tb/bt_loader_bench.sv
module bt_loader_bench;
    localparam int AW = 32;

    typedef struct { logic [31:0] d; logic l; } word_t;
    typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] be; } wr_t;
    typedef struct { logic is_err; logic [31:0] jump; string req; } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          fmt_i = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_data = '0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_data;
    logic [3:0]    mem_be;
    logic          mem_ready = 1'b1;
    logic          done;
    logic          err;
    logic [AW-1:0] jump_addr;

    bt_loader #(.ADDR_W(AW), .CNT_W(32)) u_bt_loader (
        .clk(clk), .rst(rst), .fmt_i(fmt_i),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .mem_ready(mem_ready), .done(done), .err(err), .jump_addr(jump_addr)
    );

    int    checks = 0;
    int    errors = 0;
    word_t wq[$];
    wr_t   xq[$];
    ev_t   eq[$];
    int    gap_n = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] lane_mask(input int rem);
        if (rem >= 4) return 4'b1111;
        case (rem)
            1: return 4'b1000;
            2: return 4'b1100;
            default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] base, input int i);
        return (base * 32'h0000_9E37) ^ (32'(i) * 32'h0103_0507) ^ 32'h5A5A_0000;
    endfunction

    task automatic q_word(input logic [31:0] d, input logic l);
        word_t w;
        w.d = d; w.l = l;
        wq.push_back(w);
    endtask

    // Section header plus nw data words; last flag on final data word if cut
    task automatic q_sect(input logic [31:0] base, input int len, input int nw, input bit cut);
        wr_t x;
        q_word(32'(len), 1'b0);
        q_word(base, 1'b0);
        for (int i = 0; i < nw; i++) begin
            q_word(pat(base, i), cut && (i == nw - 1));
            x.a = base + 32'(4 * i); x.d = pat(base, i); x.be = lane_mask(len - 4 * i);
            xq.push_back(x);
        end
    endtask

    task automatic q_event(input logic is_err, input logic [31:0] jump, input string req);
        ev_t e;
        e.is_err = is_err; e.jump = jump; e.req = req;
        eq.push_back(e);
    endtask

    task automatic send_all();
        word_t w;
        while (wq.size() > 0) begin
            w = wq.pop_front();
            in_valid = 1'b1; in_data = w.d; in_last = w.l;
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
            in_valid = 1'b0; in_last = 1'b0;
            gap_n++;
            if (gap_n % 3 == 0) begin
                @(posedge clk); #1;
            end
        end
    endtask

    task automatic drain();
        while (eq.size() > 0 || xq.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Memory-side ready pattern
    int unsigned lcg = 32'h1234_5678;
    bit rdy_rand = 1'b0;
    initial begin
        forever begin
            @(posedge clk); #1;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            mem_ready = rdy_rand ? (lcg[17:16] != 2'b00) : 1'b1;
        end
    end

    // Cycle-by-cycle comparison against the queued expectations
    bit          hold_prev = 1'b0;
    logic [31:0] h_addr, h_data;
    logic [3:0]  h_be;
    bit          done_prev = 1'b0;
    bit          err_prev = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (hold_prev)
                    chk(mem_we && mem_addr == h_addr && mem_be == h_be && mem_data == h_data,
                        "R7", "stalled write changed", mem_addr, h_addr);
                if (mem_we && !mem_ready)
                    chk(!in_ready, "R7", "in_ready during stall", 32'(in_ready), 32'd0);
                hold_prev = mem_we && !mem_ready;
                h_addr = mem_addr; h_data = mem_data; h_be = mem_be;
                if (mem_we && mem_ready) begin
                    if (xq.size() == 0) begin
                        chk(1'b0, "R4", "unexpected write", mem_addr, 32'd0);
                    end else begin
                        wr_t x;
                        x = xq.pop_front();
                        chk(mem_addr == x.a, "R4", "write address", mem_addr, x.a);
                        chk(mem_data == x.d, "R4", "write data", mem_data, x.d);
                        chk(mem_be == x.be, "R5", "byte enables", 32'(mem_be), 32'(x.be));
                    end
                end
                if ((done && done_prev) || (err && err_prev) || (done && err))
                    chk(1'b0, "R9", "pulse shape", {30'd0, done, err}, 32'd0);
                if (done || err) begin
                    if (eq.size() == 0) begin
                        chk(1'b0, "R8", "unexpected event", {30'd0, done, err}, 32'd0);
                    end else begin
                        ev_t e;
                        e = eq.pop_front();
                        chk(err == e.is_err, e.req, "event kind (err)", 32'(err), 32'(e.is_err));
                        if (done)
                            chk(jump_addr == e.jump, e.req, "jump address", jump_addr, e.jump);
                        if (err)
                            chk(xq.size() == 0, e.req, "writes pending at error", 32'(xq.size()), 32'd0);
                    end
                end
                done_prev = done;
                err_prev = err;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_we && jump_addr == '0, "R1", "outputs in reset",
            {29'd0, done, err, mem_we}, 32'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !err && !mem_we && jump_addr == '0, "R1", "outputs after reset",
            {29'd0, done, err, mem_we}, 32'd0);
        @(posedge clk); #1;

        // R2 standard table: entry word, full and partial sections
        fmt_i = 1'b0;
        q_word(32'h8000_0100, 1'b0);
        q_sect(32'h0000_1000, 8, 2, 1'b0);
        q_sect(32'h0000_2000, 5, 2, 1'b0);
        q_word(32'h0, 1'b1);
        q_event(1'b0, 32'h8000_0100, "R2");
        send_all(); drain();

        // R3 header-only table: jump is last section base; lengths 3,6,1
        rdy_rand = 1'b1;
        fmt_i = 1'b1;
        q_sect(32'h0000_3000, 3, 1, 1'b0);
        q_sect(32'h0000_4000, 6, 2, 1'b0);
        q_sect(32'h0000_5000, 1, 1, 1'b0);
        q_word(32'h0, 1'b1);
        q_event(1'b0, 32'h0000_5000, "R3");
        send_all(); drain();

        // R3 empty header-only table gives jump 0
        q_word(32'h0, 1'b1);
        q_event(1'b0, 32'h0, "R3");
        send_all(); drain();

        // R6 switch back to standard; lengths 2 and 7 under stalls
        fmt_i = 1'b0;
        q_word(32'hC0DE_0040, 1'b0);
        q_sect(32'h0001_0000, 2, 1, 1'b0);
        q_sect(32'h0002_0010, 7, 2, 1'b0);
        q_sect(32'h0003_0000, 16, 4, 1'b0);
        q_word(32'h0, 1'b0);
        q_event(1'b0, 32'hC0DE_0040, "R6");
        send_all(); drain();

        // R8 stream cut inside section data: written words still land
        q_word(32'h1111_0000, 1'b0);
        q_sect(32'h0004_0000, 12, 2, 1'b1);
        q_event(1'b1, 32'h0, "R8");
        send_all(); drain();

        // R8 stream cut on a header word in header-only format: no writes
        fmt_i = 1'b1;
        q_word(32'd20, 1'b1);
        q_event(1'b1, 32'h0, "R8");
        send_all(); drain();
        chk(jump_addr == 32'hC0DE_0040, "R8", "jump unchanged after error", jump_addr, 32'hC0DE_0040);

        // R6 recovery after error, standard format again
        fmt_i = 1'b0;
        q_word(32'h0BAD_F00C, 1'b0);
        q_sect(32'h0005_0000, 9, 3, 1'b0);
        q_word(32'h0, 1'b1);
        q_event(1'b0, 32'h0BAD_F00C, "R6");
        send_all(); drain();

        chk(xq.size() == 0 && eq.size() == 0, "R4", "leftover expectations",
            32'(xq.size() + eq.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule